// File: doc/BRIEF.md
# Host Byte Lane Aligner

This block sits between a host bus and a 32-bit memory data path. It steers byte, half-word and word accesses onto the correct memory byte lanes. On the write side it produces the memory write data and a per-lane byte-enable mask in the same cycle as the request. On the read side it moves the addressed lanes of the returned memory word to where the host expects them. It captures that result in a register on the clock edge where the read-valid strobe is high.

The parameter `ALIGN_LOW` picks one of two placements. With `ALIGN_LOW = 0` (lane-placed mode), narrow data occupies the host lanes chosen by the low address bits, in the same positions it takes in memory. With `ALIGN_LOW = 1` (low-justified mode), narrow data always occupies the least significant bits of the host bus. This lets a narrow host reach every byte of the wide memory. Memory command sequencing and timing belong to the surrounding controller and are not part of this block.

Size code on `acc_size`: 0 = byte, 1 = half-word, 2 = word, 3 = treated as word. Lane n is bits [8n+7:8n] and is addressed by `addr_lo` = n (little-endian).

Top module: `lane_aligner`

## Requirements
- R1: For a byte access (size 0), `mem_be` has exactly bit n set, where n = `addr_lo`.
- R2: For a half-word access (size 1), `mem_be` is 4'b0011 when `addr_lo[1]`=0 and 4'b1100 when `addr_lo[1]`=1; `addr_lo[0]` has no effect.
- R3: For size 2 and for the reserved size 3, `mem_be` is 4'b1111 and data moves as a full word.
- R4: In lane-placed mode, each enabled lane of `mem_wdata` equals the same lane of `host_wdata`, and each disabled lane is zero.
- R5: In low-justified mode, `mem_wdata` is host bits [7:0] repeated on all four lanes for a byte, host bits [15:0] repeated on both halves for a half-word, and `host_wdata` unchanged for a word.
- R6: In lane-placed mode, the read result holds each enabled lane of `mem_rdata` in the same position, with all other lanes zero.
- R7: In low-justified mode, the read result holds the addressed byte on bits [7:0] or the addressed half-word on bits [15:0], with all higher bits zero. A word read returns `mem_rdata` unchanged.
- R8: `host_rdata` takes the steered value at the rising edge where `rd_valid` is 1, using the size and address present in that cycle. It holds its value at every edge where `rd_valid` is 0.
- R9: While `rst` is high at a rising edge, `host_rdata` becomes zero, whatever `rd_valid` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| acc_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 word) |
| addr_lo | input | 2 | Low address bits selecting the lane |
| host_wdata | input | 32 | Write data from the host |
| mem_rdata | input | 32 | Read data returned by the memory |
| rd_valid | input | 1 | Capture strobe for the read result |
| mem_wdata | output | 32 | Lane-steered write data to the memory |
| mem_be | output | 4 | Byte-enable mask, one bit per lane |
| host_rdata | output | 32 | Registered, steered read data to the host |

## Verification
The hardest case to reach from the ports is the one that shows the read register holding its value. To see it, a capture must happen, and then the memory data, size and address must all change while the strobe is low. The stimulus does this after every read capture: it drops `rd_valid`, loads a new memory word with a different size and offset, and clocks once before it samples. Both modes run side by side on one stimulus stream. The address loop includes the odd half-word offsets, so each mode shows that `addr_lo[0]` is ignored for half-words.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

    // Access width carried on the host request.
    typedef enum logic [1:0] {
        SZ_LANE = 2'd0,
        SZ_PAIR = 2'd1,
        SZ_FULL = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    // Decoded view of a request shared by the steering stages.
    typedef struct packed {
        logic is_lane;
        logic is_pair;
        logic is_full;
    } acc_kind_t;

    function automatic acc_kind_t decode_size(input logic [1:0] code);
        acc_kind_t k;
        k = '0;
        unique case (acc_size_e'(code))
            SZ_LANE: k.is_lane = 1'b1;
            SZ_PAIR: k.is_pair = 1'b1;
            default: k.is_full = 1'b1;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/lane_mask_gen.sv
module lane_mask_gen
    import lane_align_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFS_W = $clog2(LANES)
) (
    input  acc_kind_t          kind,
    input  logic [OFS_W-1:0]   ofs,
    output logic [LANES-1:0]   be
);

    localparam logic [LANES-1:0] ONE_LANE = {{(LANES-1){1'b0}}, 1'b1};
    localparam logic [LANES-1:0] TWO_LANE = {{(LANES-2){1'b0}}, 2'b11};

    logic [OFS_W-1:0] pair_base;

    always_comb begin
        pair_base = {ofs[OFS_W-1:1], 1'b0};
        if (kind.is_lane)
            be = ONE_LANE << ofs;
        else if (kind.is_pair)
            be = TWO_LANE << pair_base;
        else
            be = '1;
    end

endmodule

// File: rtl/lane_write_steer.sv
module lane_write_steer
    import lane_align_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int LANES     = 4,
    parameter bit ALIGN_LOW = 1'b0,
    localparam int DATA_W   = LANE_W * LANES
) (
    input  acc_kind_t          kind,
    input  logic [LANES-1:0]   be,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  mem_wdata
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (ALIGN_LOW) begin : g_low
            // Narrow data is repeated so the mask alone picks the lane.
            always_comb begin
                if (kind.is_lane)
                    mem_wdata[i*LANE_W +: LANE_W] = host_wdata[LANE_W-1:0];
                else if (kind.is_pair)
                    mem_wdata[i*LANE_W +: LANE_W] = host_wdata[(i%2)*LANE_W +: LANE_W];
                else
                    mem_wdata[i*LANE_W +: LANE_W] = host_wdata[i*LANE_W +: LANE_W];
            end
        end else begin : g_nat
            // Data already sits on its lane; unused lanes are cleared.
            always_comb begin
                mem_wdata[i*LANE_W +: LANE_W] =
                    be[i] ? host_wdata[i*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/lane_read_steer.sv
module lane_read_steer
    import lane_align_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int LANES     = 4,
    parameter bit ALIGN_LOW = 1'b0,
    localparam int DATA_W   = LANE_W * LANES,
    localparam int OFS_W    = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_valid,
    input  acc_kind_t          kind,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [LANES-1:0]   be,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  host_rdata
);

    logic [DATA_W-1:0] steered;

    if (ALIGN_LOW) begin : g_low
        logic [OFS_W-1:0] pair_base;
        always_comb begin
            pair_base = {ofs[OFS_W-1:1], 1'b0};
            steered   = '0;
            if (kind.is_lane)
                steered[LANE_W-1:0] = mem_rdata[ofs*LANE_W +: LANE_W];
            else if (kind.is_pair)
                steered[2*LANE_W-1:0] = mem_rdata[pair_base*LANE_W +: 2*LANE_W];
            else
                steered = mem_rdata;
        end
    end else begin : g_nat
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            always_comb begin
                steered[i*LANE_W +: LANE_W] =
                    be[i] ? mem_rdata[i*LANE_W +: LANE_W] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (rd_valid)
            host_rdata <= steered;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> $stable(host_rdata)); // R8

    if (ALIGN_LOW) begin : g_chk_low
        AST_RD_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
            (rd_valid && kind.is_lane) |=> (host_rdata[DATA_W-1:LANE_W] == '0)); // R7
    end

endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
    import lane_align_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int LANES     = 4,
    parameter bit ALIGN_LOW = 1'b0,
    localparam int DATA_W   = LANE_W * LANES,
    localparam int OFS_W    = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         acc_size,
    input  logic [OFS_W-1:0]   addr_lo,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               rd_valid,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [LANES-1:0]   mem_be,
    output logic [DATA_W-1:0]  host_rdata
);

    acc_kind_t kind;
    assign kind = decode_size(acc_size);

    lane_mask_gen #(.LANES(LANES)) u_mask (
        .kind (kind),
        .ofs  (addr_lo),
        .be   (mem_be)
    );

    lane_write_steer #(.LANE_W(LANE_W), .LANES(LANES), .ALIGN_LOW(ALIGN_LOW)) u_wr (
        .kind       (kind),
        .be         (mem_be),
        .host_wdata (host_wdata),
        .mem_wdata  (mem_wdata)
    );

    lane_read_steer #(.LANE_W(LANE_W), .LANES(LANES), .ALIGN_LOW(ALIGN_LOW)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_valid   (rd_valid),
        .kind       (kind),
        .ofs        (addr_lo),
        .be         (mem_be),
        .mem_rdata  (mem_rdata),
        .host_rdata (host_rdata)
    );

    AST_LANE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (acc_size == 2'd0) |-> ($countones(mem_be) == 1 && mem_be[addr_lo])); // R1

    AST_PAIR_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        (acc_size == 2'd1) |-> ($countones(mem_be) == 2
                                && mem_be[{addr_lo[OFS_W-1:1], 1'b0}])); // R2

    AST_FULL_ALL: assert property (@(posedge clk) disable iff (rst)
        acc_size[1] |-> (mem_be == {LANES{1'b1}})); // R3

    if (!ALIGN_LOW) begin : g_chk_nat
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            AST_WR_UNSEL_ZERO: assert property (@(posedge clk) disable iff (rst)
                !mem_be[i] |-> (mem_wdata[i*LANE_W +: LANE_W] == '0)); // R4
        end
    end

endmodule

// File: tb/sim_lane_aligner.sv
module sim_lane_aligner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  acc_size = 2'd0;
    logic [1:0]  addr_lo = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic        rd_valid = 1'b0;
    logic [31:0] wd_nat, wd_low, rd_nat, rd_low;
    logic [3:0]  be_nat, be_low;

    int vec_cnt = 0;
    int bad_cnt = 0;

    always #2 clk = ~clk; // 250 MHz

    lane_aligner #(.ALIGN_LOW(1'b0)) u0 (
        .clk(clk), .rst(rst), .acc_size(acc_size), .addr_lo(addr_lo),
        .host_wdata(host_wdata), .mem_rdata(mem_rdata), .rd_valid(rd_valid),
        .mem_wdata(wd_nat), .mem_be(be_nat), .host_rdata(rd_nat));

    lane_aligner #(.ALIGN_LOW(1'b1)) u1 (
        .clk(clk), .rst(rst), .acc_size(acc_size), .addr_lo(addr_lo),
        .host_wdata(host_wdata), .mem_rdata(mem_rdata), .rd_valid(rd_valid),
        .mem_wdata(wd_low), .mem_be(be_low), .host_rdata(rd_low));

    // ---------------- reference model ----------------
    function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'd0:    return 4'b0001 << a;
            2'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] ref_keep(input logic [3:0] be, input logic [31:0] d);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? d[b*8 +: 8] : 8'h00;
        return r;
    endfunction

    function automatic logic [31:0] ref_wr_low(input logic [1:0] sz, input logic [31:0] h);
        case (sz)
            2'd0:    return {4{h[7:0]}};
            2'd1:    return {2{h[15:0]}};
            default: return h;
        endcase
    endfunction

    function automatic logic [31:0] ref_rd_low(input logic [1:0] sz, input logic [1:0] a,
                                               input logic [31:0] m);
        logic [31:0] sh;
        sh = m >> (8 * a);
        case (sz)
            2'd0:    return {24'h0, sh[7:0]};
            2'd1:    return a[1] ? {16'h0, m[31:16]} : {16'h0, m[15:0]};
            default: return m;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s size=%0d addr=%0d act=%h exp=%h",
                     req, acc_size, addr_lo, act, exp);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic test_reset();
        rst = 1'b1; rd_valid = 1'b1; mem_rdata = 32'hDEAD_BEEF; acc_size = 2'd2;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 natural", rd_nat, 32'h0);
        chk("R9 low", rd_low, 32'h0);
        @(negedge clk);
        rst = 1'b0; rd_valid = 1'b0;
    endtask

    task automatic test_masks();
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 4; a++) begin
                @(negedge clk);
                acc_size = 2'(s); addr_lo = 2'(a);
                #1;
                if (s == 0)      chk("R1 be", {28'h0, be_nat}, {28'h0, ref_be(2'(s), 2'(a))});
                else if (s == 1) chk("R2 be", {28'h0, be_nat}, {28'h0, ref_be(2'(s), 2'(a))});
                else             chk("R3 be", {28'h0, be_low}, 32'hF);
                chk("R1 R2 R3 be both modes", {28'h0, be_low}, {28'h0, be_nat});
            end
    endtask

    task automatic test_writes(input logic [31:0] h);
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 4; a++) begin
                @(negedge clk);
                acc_size = 2'(s); addr_lo = 2'(a); host_wdata = h;
                #1;
                chk("R4 natural write", wd_nat, ref_keep(ref_be(2'(s), 2'(a)), h));
                chk("R5 low write", wd_low, ref_wr_low(2'(s), h));
            end
    endtask

    task automatic test_reads(input logic [31:0] m);
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 4; a++) begin
                logic [31:0] e_nat, e_low;
                @(negedge clk);
                acc_size = 2'(s); addr_lo = 2'(a); mem_rdata = m; rd_valid = 1'b1;
                e_nat = ref_keep(ref_be(2'(s), 2'(a)), m);
                e_low = ref_rd_low(2'(s), 2'(a), m);
                @(posedge clk);
                #1;
                chk("R6 natural read", rd_nat, e_nat);
                chk("R7 low read", rd_low, e_low);
                // strobe low: change everything, result must hold
                @(negedge clk);
                rd_valid = 1'b0; mem_rdata = ~m; acc_size = 2'(3 - s); addr_lo = 2'(3 - a);
                @(posedge clk);
                #1;
                chk("R8 hold natural", rd_nat, e_nat);
                chk("R8 hold low", rd_low, e_low);
            end
    endtask

    initial begin
        test_reset();
        test_masks();
        test_writes(32'h4433_2211);
        test_writes(32'hA5C3_F00F);
        test_writes(32'hFFFF_FFFF);
        test_reads(32'h8877_6655);
        test_reads(32'h0F1E_2D3C);
        test_reads(32'h8000_0001);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        #(200000 * 4);
        bad_cnt++;
        $display("FAIL watchdog expired act=%0d exp=0", vec_cnt);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

endmodule